// File: doc/BRIEF.md
# Display Memory Fetch Sequencer

This block feeds a raster display engine. Software sets up a palette base, one or two frame regions, a burst size code, a load mode and an enable. The sequencer then walks memory in bursts through a request/grant/read-beat interface. Palette words go out on a write port into the palette store. Frame words go into a first-in first-out pixel queue, and the pixel serialiser drains that queue.

Each frame region is given by a base byte address and an inclusive ceiling byte address, so the ceiling is the last byte of the region. When dual-buffer operation is selected, successive passes alternate between region 0 and region 1. Otherwise region 0 is fetched again and again. A region's addresses are captured when its pass starts, so software may move a region after its end-of-frame flag and the change applies on that region's next pass. Events are recorded in a sticky status vector, and each bit is cleared by writing 1 to it.

Top module: `lcd_fetch_seq`

## Requirements
- R1: After reset, `mem_req`, `pix_valid` and `pal_we` are 0 and `sts` is all zeros. No request is made until `en` is 1.
- R2: `burst_code` values 0, 1, 2, 3 and 4 give bursts of 1, 2, 4, 8 and 16 words (one word is 4 bytes). Codes 5 to 7 are treated as 16.
- R3: A pass over a region covers (ceiling - base + 1)/4 words, starting at base. Successive requests advance by 4 x `mem_len` bytes. The last burst of a pass is shortened to the words that remain, so no burst reaches past the ceiling.
- R4: Frame words enter the pixel queue in arrival order. `pix_data` shows the oldest word while `pix_valid` is 1, and `pix_pop` removes it.
- R5: With `dual_buf` = 0, only region 0 is fetched. Finishing its pass sets `sts` bit 8 and the next pass starts again at base 0. Bit 9 stays 0.
- R6: With `dual_buf` = 1, passes alternate region 0, region 1, region 0 and so on. The end of a region-0 pass sets bit 8 and the end of a region-1 pass sets bit 9.
- R7: `load_mode` = 0 first fetches the palette from `pal_base`. That is 8 words for 16 entries (`pal_large` = 0) or 128 words for 256 entries (`pal_large` = 1). Word i is written with `pal_waddr` = i. The sequencer then sets `sts` bit 6 and continues with region 0.
- R8: `load_mode` = 1 fetches the palette and sets bit 6. It makes no further request while `en` stays 1.
- R9: `load_mode` = 2 or 3 skips the palette and starts at region 0.
- R10: Region addresses are captured at the start of each pass. A change written during a pass applies from that region's next pass.
- R11: A frame burst is requested only when the free space in the queue (depth 32) is at least the burst length. Only one burst is outstanding at a time, so no new request is made before the previous burst's last beat.
- R12: Popping an empty queue sets `sts` bit 5 and leaves the queue empty.
- R13: A pulse on `sts_clr_we` clears every `sts` bit whose `sts_clr_mask` bit is 1. An event arriving in the same cycle keeps its bit set.
- R14: After `en` falls, no new request is made, but a burst already granted still completes. Raising `en` again restarts from the beginning (palette or region 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| load_mode | input | 2 | 0 palette then frames, 1 palette only, 2/3 frames only |
| burst_code | input | 3 | Burst length code |
| dual_buf | input | 1 | Alternate between regions 0 and 1 |
| pal_large | input | 1 | 1 selects a 256-entry palette, 0 a 16-entry palette |
| pal_base | input | 32 | Palette byte address |
| fb0_base | input | 32 | Region 0 first byte |
| fb0_ceil | input | 32 | Region 0 last byte |
| fb1_base | input | 32 | Region 1 first byte |
| fb1_ceil | input | 32 | Region 1 last byte |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 5 | Burst length in words |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| pal_we | output | 1 | Palette word write strobe |
| pal_waddr | output | 8 | Palette word index |
| pal_wdata | output | 32 | Palette word |
| pix_pop | input | 1 | Consumer removes head word |
| pix_valid | output | 1 | Queue holds a word |
| pix_data | output | 32 | Head word of the queue |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 10 | Bits to clear |
| sts | output | 10 | Status: 9 end region 1, 8 end region 0, 6 palette done, 5 underflow |

## Verification
The bench answers every request with data equal to the word's own address. A wrong address counter or a wrong region select therefore shows up in the request log, which records address and length, and in the popped pixel data. It appears from the first burst after the fault. A wrong pass length or a mis-decoded burst size shows in the `mem_len` values and in the address step, and it appears no later than the end of the first pass. An end-of-pass or mode-sequencing fault shows as a missing status bit, or as requests that continue when they should stop or stop when they should continue. An accounting error in the queue shows as a request made while the queue is full, or as no request after it drains.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;
  localparam int BURST_LEN_W = 5;
  localparam int STS_W       = 10;
  localparam int PAL_IDX_W   = 8;
  localparam int STS_UNDERRUN = 5;
  localparam int STS_PAL_DONE = 6;
  localparam int STS_END0     = 8;
  localparam int STS_END1     = 9;
  localparam logic [1:0] MODE_PAL_FRAME = 2'd0;
  localparam logic [1:0] MODE_PAL_ONLY  = 2'd1;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PREQ, SQ_PDAT, SQ_HOLD, SQ_FREQ, SQ_FDAT
  } seq_state_e;

  function automatic logic [BURST_LEN_W-1:0] burst_words(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/lcdf_fifo.sv
module lcdf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic                         not_empty,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_ok;

  assign pop_ok    = pop && (cnt_q != '0);
  assign underrun  = pop && (cnt_q == '0);
  assign head      = store[rd_q];
  assign not_empty = (cnt_q != '0);
  assign count     = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (pop_ok) rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    case ({push, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= push_data;
  end

  // R11
  queue_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));

  // R12
  queue_underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/lcdf_status.sv
module lcdf_status #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);
  logic [W-1:0] flg_q, flg_d;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign flg_d[gi] = ev[gi] | (flg_q[gi] & ~(clr_we & clr_mask[gi]));

    // R13
    sts_set_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[gi]) |-> $past(ev[gi]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/lcdf_ctrl.sv
module lcdf_ctrl
  import lcdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WB     = 4,
  parameter int DEPTH  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [1:0]                    load_mode,
  input  logic [2:0]                    burst_code,
  input  logic                          dual_buf,
  input  logic                          pal_large,
  input  logic [ADDR_W-1:0]             pal_base,
  input  logic [ADDR_W-1:0]             fb0_base,
  input  logic [ADDR_W-1:0]             fb0_ceil,
  input  logic [ADDR_W-1:0]             fb1_base,
  input  logic [ADDR_W-1:0]             fb1_ceil,
  input  logic [$clog2(DEPTH+1)-1:0]    fifo_count,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [BURST_LEN_W-1:0]        mem_len,
  input  logic                          mem_gnt,
  input  logic                          mem_rvalid,
  output logic                          fifo_push,
  output logic                          pal_wr,
  output logic [PAL_IDX_W-1:0]          pal_idx,
  output logic                          ev_pal,
  output logic                          ev_end0,
  output logic                          ev_end1
);
  localparam int SH     = $clog2(WB);
  localparam int CW     = $clog2(DEPTH+1);
  localparam int PALW_S = 32 / WB;
  localparam int PALW_L = 512 / WB;

  seq_state_e                 st_q, st_d;
  logic                       buf_q, buf_d;
  logic [ADDR_W-1:0]          addr_q, addr_d, lim_q, lim_d, rem_q, rem_d;
  logic [BURST_LEN_W-1:0]     beats_q, beats_d, bw, req_len;
  logic [PAL_IDX_W-1:0]       pidx_q, pidx_d;
  logic [CW-1:0]              free_words;
  logic                       space_ok, accept, load_pass, nbuf;
  logic [ADDR_W-1:0]          sel_base, sel_ceil, pal_n;

  assign bw         = burst_words(burst_code);
  assign req_len    = (rem_q < ADDR_W'(bw)) ? BURST_LEN_W'(rem_q) : bw;
  assign free_words = CW'(DEPTH) - fifo_count;
  assign space_ok   = (32'(free_words) >= 32'(req_len));
  assign mem_req    = en && ((st_q == SQ_PREQ) || ((st_q == SQ_FREQ) && space_ok));
  assign accept     = mem_req && mem_gnt;
  assign mem_addr   = addr_q;
  assign mem_len    = req_len;
  assign pal_idx    = pidx_q;
  assign pal_n      = pal_large ? ADDR_W'(PALW_L) : ADDR_W'(PALW_S);

  always_comb begin
    st_d      = st_q;
    buf_d     = buf_q;
    addr_d    = addr_q;
    lim_d     = lim_q;
    rem_d     = rem_q;
    beats_d   = beats_q;
    pidx_d    = pidx_q;
    load_pass = 1'b0;
    nbuf      = 1'b0;
    fifo_push = 1'b0;
    pal_wr    = 1'b0;
    ev_pal    = 1'b0;
    ev_end0   = 1'b0;
    ev_end1   = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (en) begin
          if ((load_mode == MODE_PAL_FRAME) || (load_mode == MODE_PAL_ONLY)) begin
            st_d   = SQ_PREQ;
            addr_d = pal_base;
            rem_d  = pal_n;
            lim_d  = pal_base + (pal_n << SH) - 1'b1;
            pidx_d = '0;
          end else begin
            load_pass = 1'b1;
            st_d      = SQ_FREQ;
          end
        end
      end
      SQ_PREQ, SQ_FREQ: begin
        if (!en) begin
          st_d = SQ_IDLE;
        end else if (accept) begin
          addr_d  = addr_q + (ADDR_W'(req_len) << SH);
          rem_d   = rem_q - ADDR_W'(req_len);
          beats_d = req_len;
          st_d    = (st_q == SQ_PREQ) ? SQ_PDAT : SQ_FDAT;
        end
      end
      SQ_PDAT: begin
        if (mem_rvalid) begin
          pal_wr  = 1'b1;
          pidx_d  = pidx_q + 1'b1;
          beats_d = beats_q - 1'b1;
          if (beats_q == BURST_LEN_W'(1)) begin
            if (rem_q == '0) begin
              ev_pal = 1'b1;
              if (!en) begin
                st_d = SQ_IDLE;
              end else if (load_mode == MODE_PAL_ONLY) begin
                st_d = SQ_HOLD;
              end else begin
                load_pass = 1'b1;
                st_d      = SQ_FREQ;
              end
            end else begin
              st_d = en ? SQ_PREQ : SQ_IDLE;
            end
          end
        end
      end
      SQ_HOLD: begin
        if (!en) st_d = SQ_IDLE;
      end
      SQ_FDAT: begin
        if (mem_rvalid) begin
          fifo_push = 1'b1;
          beats_d   = beats_q - 1'b1;
          if (beats_q == BURST_LEN_W'(1)) begin
            if (rem_q == '0) begin
              ev_end0   = !buf_q;
              ev_end1   = buf_q;
              load_pass = 1'b1;
              nbuf      = dual_buf & ~buf_q;
            end
            st_d = en ? SQ_FREQ : SQ_IDLE;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
    sel_base = nbuf ? fb1_base : fb0_base;
    sel_ceil = nbuf ? fb1_ceil : fb0_ceil;
    if (load_pass) begin
      buf_d  = nbuf;
      addr_d = sel_base;
      lim_d  = sel_ceil;
      rem_d  = (sel_ceil - sel_base + 1'b1) >> SH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      buf_q   <= 1'b0;
      addr_q  <= '0;
      lim_q   <= '0;
      rem_q   <= '0;
      beats_q <= '0;
      pidx_q  <= '0;
    end else begin
      st_q    <= st_d;
      buf_q   <= buf_d;
      addr_q  <= addr_d;
      lim_q   <= lim_d;
      rem_q   <= rem_d;
      beats_q <= beats_d;
      pidx_q  <= pidx_d;
    end
  end

  // R3
  burst_within_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (({1'b0, addr_q} + ({1'b0, ADDR_W'(req_len)} << SH) - 1'b1) <= {1'b0, lim_q}));

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_req);

  // R5
  no_second_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_buf && ev_end0) |=> !buf_q);
endmodule

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq
  import lcdf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [1:0]               load_mode,
  input  logic [2:0]               burst_code,
  input  logic                     dual_buf,
  input  logic                     pal_large,
  input  logic [ADDR_W-1:0]        pal_base,
  input  logic [ADDR_W-1:0]        fb0_base,
  input  logic [ADDR_W-1:0]        fb0_ceil,
  input  logic [ADDR_W-1:0]        fb1_base,
  input  logic [ADDR_W-1:0]        fb1_ceil,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [BURST_LEN_W-1:0]   mem_len,
  input  logic                     mem_gnt,
  input  logic                     mem_rvalid,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     pal_we,
  output logic [PAL_IDX_W-1:0]     pal_waddr,
  output logic [DATA_W-1:0]        pal_wdata,
  input  logic                     pix_pop,
  output logic                     pix_valid,
  output logic [DATA_W-1:0]        pix_data,
  input  logic                     sts_clr_we,
  input  logic [STS_W-1:0]         sts_clr_mask,
  output logic [STS_W-1:0]         sts
);
  localparam int WB = DATA_W / 8;
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [CW-1:0]        fcount;
  logic                 push, underrun, pal_wr, ev_pal, ev_end0, ev_end1;
  logic [PAL_IDX_W-1:0] pal_idx;
  logic [STS_W-1:0]     ev_vec;

  lcdf_ctrl #(.ADDR_W(ADDR_W), .WB(WB), .DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk, .rst_n, .en, .load_mode, .burst_code, .dual_buf, .pal_large,
    .pal_base, .fb0_base, .fb0_ceil, .fb1_base, .fb1_ceil,
    .fifo_count(fcount), .mem_req, .mem_addr, .mem_len, .mem_gnt, .mem_rvalid,
    .fifo_push(push), .pal_wr, .pal_idx, .ev_pal, .ev_end0, .ev_end1
  );

  lcdf_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .push, .push_data(mem_rdata), .pop(pix_pop),
    .head(pix_data), .not_empty(pix_valid), .count(fcount), .underrun
  );

  always_comb begin
    ev_vec               = '0;
    ev_vec[STS_UNDERRUN] = underrun;
    ev_vec[STS_PAL_DONE] = ev_pal;
    ev_vec[STS_END0]     = ev_end0;
    ev_vec[STS_END1]     = ev_end1;
  end

  lcdf_status #(.W(STS_W)) u_sts (
    .clk, .rst_n, .ev(ev_vec), .clr_we(sts_clr_we), .clr_mask(sts_clr_mask), .flags(sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_we    <= 1'b0;
      pal_waddr <= '0;
      pal_wdata <= '0;
    end else begin
      pal_we <= pal_wr;
      if (pal_wr) begin
        pal_waddr <= pal_idx;
        pal_wdata <= mem_rdata;
      end
    end
  end

  // R12
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_pop && !pix_valid) |=> sts[STS_UNDERRUN]);
endmodule

// File: tb/tb_lcd_fetch_seq.sv
`timescale 1ns/1ps
module tb_lcd_fetch_seq;
  logic        clk, rst_n, en, dual_buf, pal_large, mem_req, mem_gnt, mem_rvalid;
  logic [1:0]  load_mode;
  logic [2:0]  burst_code;
  logic [31:0] pal_base, fb0_base, fb0_ceil, fb1_base, fb1_ceil, mem_addr, mem_rdata;
  logic [4:0]  mem_len;
  logic        pal_we, pix_pop, pix_valid, sts_clr_we;
  logic [7:0]  pal_waddr;
  logic [31:0] pal_wdata, pix_data;
  logic [9:0]  sts_clr_mask, sts;

  int n_tests = 0, n_fail = 0;
  int req_n = 0, pal_cnt = 0, ovl_err = 0, beats_pend = 0;
  logic [31:0] req_a [64];
  logic [4:0]  req_l [64];
  logic [31:0] raddr, pal_last_d;
  logic [7:0]  pal_last_a;

  lcd_fetch_seq dut (.*);

  initial begin clk = 0; forever #10 clk = ~clk; end

  // memory responder: data returned equals word address
  initial begin
    mem_rvalid = 0; mem_rdata = 0; raddr = 0;
    forever begin
      @(negedge clk);
      if (pal_we) begin pal_cnt++; pal_last_a = pal_waddr; pal_last_d = pal_wdata; end
      if (beats_pend > 0) begin
        mem_rvalid = 1; mem_rdata = raddr; raddr += 4; beats_pend--;
      end else mem_rvalid = 0;
      if (mem_req && mem_gnt) begin
        if (beats_pend != 0) ovl_err++;
        if (req_n < 64) begin req_a[req_n] = mem_addr; req_l[req_n] = mem_len; end
        req_n++;
        beats_pend = mem_len;
        raddr = mem_addr;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wait_req(input int n, input int maxc);
    for (int i = 0; i < maxc && req_n < n; i++) tick(1);
  endtask

  task automatic pop_one(input string tag, input logic [31:0] exp);
    chk({tag, " valid"}, pix_valid, 1);
    chk(tag, pix_data, exp);
    pix_pop = 1; tick(1); pix_pop = 0;
  endtask

  task automatic prep();
    en = 0; tick(40);
    for (int i = 0; i < 80 && pix_valid; i++) begin pix_pop = 1; tick(1); end
    pix_pop = 0;
    sts_clr_mask = '1; sts_clr_we = 1; tick(1); sts_clr_we = 0; sts_clr_mask = '0;
    req_n = 0; pal_cnt = 0; ovl_err = 0;
    dual_buf = 0; pal_large = 0; load_mode = 2; burst_code = 4;
  endtask

  task automatic t_reset();
    chk("R1 mem_req", mem_req, 0);
    chk("R1 pix_valid", pix_valid, 0);
    chk("R1 pal_we", pal_we, 0);
    chk("R1 sts", sts, 0);
    tick(5);
    chk("R1 no request while disabled", req_n, 0);
  endtask

  task automatic t_single_buf();
    prep();
    load_mode = 2; burst_code = 2; fb0_base = 32'h100; fb0_ceil = 32'h11B;
    en = 1; wait_req(3, 200); en = 0; tick(30);
    chk("R9 first addr is region0", req_a[0], 32'h100);
    chk("R2 code2 len", req_l[0], 4);
    chk("R3 second addr", req_a[1], 32'h110);
    chk("R3 tail burst shortened", req_l[1], 3);
    chk("R5 restart at base0", req_a[2], 32'h100);
    chk("R5 end0 set", sts[8], 1);
    chk("R5 end1 clear", sts[9], 0);
    for (int i = 0; i < 7; i++) pop_one("R4 pixel order", 32'h100 + 4*i);
    pop_one("R4 pixel wrap", 32'h100);
  endtask

  task automatic t_dual_buf();
    prep();
    dual_buf = 1; burst_code = 4;
    fb0_base = 32'h100; fb0_ceil = 32'h11F; fb1_base = 32'h200; fb1_ceil = 32'h207;
    en = 1; wait_req(3, 200); en = 0; tick(30);
    chk("R6 pass0 addr", req_a[0], 32'h100);
    chk("R6 pass0 len", req_l[0], 8);
    chk("R6 pass1 addr", req_a[1], 32'h200);
    chk("R6 pass1 len", req_l[1], 2);
    chk("R6 pass2 addr", req_a[2], 32'h100);
    chk("R6 end0", sts[8], 1);
    chk("R6 end1", sts[9], 1);
  endtask

  task automatic t_pal_then_data();
    prep();
    load_mode = 0; pal_large = 0; pal_base = 32'h400; burst_code = 3;
    fb0_base = 32'h100; fb0_ceil = 32'h10F;
    en = 1; wait_req(2, 200); tick(10); en = 0; tick(30);
    chk("R7 palette addr", req_a[0], 32'h400);
    chk("R7 palette len", req_l[0], 8);
    chk("R7 then region0", req_a[1], 32'h100);
    chk("R7 region0 len", req_l[1], 4);
    chk("R7 palette writes", pal_cnt, 8);
    chk("R7 last index", pal_last_a, 7);
    chk("R7 last word", pal_last_d, 32'h41C);
    chk("R7 pal done", sts[6], 1);
  endtask

  task automatic t_pal_only();
    prep();
    load_mode = 1; pal_large = 1; pal_base = 32'h800; burst_code = 4;
    en = 1; tick(400);
    chk("R8 request count", req_n, 8);
    chk("R8 step", req_a[1], 32'h840);
    chk("R7 large palette writes", pal_cnt, 128);
    chk("R7 large last index", pal_last_a, 127);
    chk("R8 pal done", sts[6], 1);
    chk("R8 no frame end", sts[8], 0);
  endtask

  task automatic t_burst_codes();
    prep();
    load_mode = 3; burst_code = 7; pal_base = 32'h400;
    fb0_base = 32'h1000; fb0_ceil = 32'h10FF;
    en = 1; wait_req(1, 100); en = 0;
    chk("R9 mode3 skips palette", req_a[0], 32'h1000);
    chk("R2 code7 as 16", req_l[0], 16);
    prep();
    burst_code = 0; fb0_base = 32'h100; fb0_ceil = 32'h107;
    en = 1; wait_req(3, 100); en = 0;
    chk("R2 code0 len", req_l[0], 1);
    chk("R3 word step", req_a[1], 32'h104);
    chk("R5 two-word pass wraps", req_a[2], 32'h100);
  endtask

  task automatic t_backpressure();
    prep();
    burst_code = 4; fb0_base = 32'h100; fb0_ceil = 32'h13F;
    en = 1; tick(200);
    chk("R11 stops when full", req_n, 2);
    chk("R11 one outstanding", ovl_err, 0);
    for (int i = 0; i < 16; i++) begin pix_pop = 1; tick(1); end
    pix_pop = 0; tick(60);
    chk("R11 resumes after drain", req_n, 3);
    en = 0;
  endtask

  task automatic t_rebase();
    prep();
    burst_code = 4; fb0_base = 32'h100; fb0_ceil = 32'h11F;
    en = 1;
    for (int i = 0; i < 200 && !sts[8]; i++) tick(1);
    fb0_base = 32'h300; fb0_ceil = 32'h31F;
    wait_req(3, 200); en = 0;
    chk("R10 current pass keeps old base", req_a[1], 32'h100);
    chk("R10 next pass uses new base", req_a[2], 32'h300);
  endtask

  task automatic t_underrun_clear();
    prep();
    pix_pop = 1; tick(1); pix_pop = 0;
    chk("R12 underrun set", sts[5], 1);
    chk("R12 still empty", pix_valid, 0);
    sts_clr_mask = 10'h100; sts_clr_we = 1; tick(1); sts_clr_we = 0;
    chk("R13 unmasked bit kept", sts[5], 1);
    sts_clr_mask = 10'h020; sts_clr_we = 1; pix_pop = 1; tick(1);
    sts_clr_we = 0; pix_pop = 0;
    chk("R13 event wins over clear", sts[5], 1);
    sts_clr_we = 1; tick(1); sts_clr_we = 0;
    chk("R13 cleared", sts[5], 0);
  endtask

  task automatic t_disable();
    prep();
    burst_code = 4; fb0_base = 32'h100; fb0_ceil = 32'h15F;
    en = 1; wait_req(1, 50); en = 0; tick(60);
    chk("R14 no request after disable", req_n, 1);
    for (int i = 0; i < 15; i++) begin pix_pop = 1; tick(1); end
    pix_pop = 0;
    pop_one("R14 granted burst completed", 32'h13C);
    en = 1; wait_req(2, 50); en = 0;
    chk("R14 restart at base0", req_a[1], 32'h100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; load_mode = 2; burst_code = 4; dual_buf = 0; pal_large = 0;
    pal_base = 0; fb0_base = 0; fb0_ceil = 0; fb1_base = 0; fb1_ceil = 0;
    mem_gnt = 1; pix_pop = 0; sts_clr_we = 0; sts_clr_mask = 0;
    tick(3);
    t_reset();
    rst_n = 1; tick(2);
    t_reset();
    t_single_buf();
    t_dual_buf();
    t_pal_then_data();
    t_pal_only();
    t_burst_codes();
    t_backpressure();
    t_rebase();
    t_underrun_clear();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule